// File: doc/BRIEF.md
# Audio DSP Power-State Sequencer

This block moves an audio DSP subsystem between its full-power state (D0) and its low-power state (D3). A one-cycle request names the target state. The block then steps through a fixed, ordered set of updates to three control words: the clock-gating word, the SRAM power-gating word and the 2-bit power-state field. Along the way it also drives the core stall and core reset lines and the master-clock enable.

Each transition starts by switching core clock gating off. It switches core clock gating back on only near the end, and waits a fixed settle time after doing so. After the SRAM bank gate mask changes, the block waits in proportion to the number of banks whose gate bit changed. After the power-state field is written, it waits a fixed settle time. Both the fixed settle time and the per-bank wait are parameters counted in clock cycles.

When the subsystem is brought up, the caller supplies a mask of the SRAM banks to keep powered. The block reports `busy` while a sequence runs and pulses `done` when the sequence completes.

Top module: `dsp_pwr_seq`

## Requirements
- R1: After reset the block is idle in D0. In that state `pwr_state`=0, `cg_ctrl`=0x00000002, `pg_ctrl`=0x00000001, `mclk_en`=1, `core_stall`=0, `core_reset`=0, `busy`=0, `done`=0 and `in_d3`=0.
- R2: Bit layout of `cg_ctrl`: bit 1 enables core clock gating, bit 10 enables trunk clock gating, and bit 31 shuts the audio PLL down. Bit layout of `pg_ctrl`: bit 0 disables D3 power gating, bit 1 disables D3 SRAM power gating, bits 11:2 gate the 10 instruction-SRAM banks and bits 31:12 gate the 20 data-SRAM banks. A mask bit of 1 means the bank is unpowered. `pwr_state` is 0 for D0 and 3 for D3.
- R3: Entering D3 follows this order. First, core and trunk clock gating are cleared. Next, the core is stalled and held in reset. Then all 30 bank gate bits are set and `pg_ctrl` bit 1 is cleared. Then the PLL is shut down and `mclk_en` is dropped in the same cycle. Then `pwr_state` becomes 3. Last, core and trunk clock gating are set. The final values are `cg_ctrl`=0x80000402 and `pg_ctrl`=0xFFFFFFFD.
- R4: After a gate-mask change, at least BANK_WAIT × (number of gate bits that changed) cycles pass before the next control update. When no gate bit needs to change, the mask is not rewritten.
- R5: At least DLY_CYC cycles pass in each of three places: after `pwr_state` is written and before the next control update, after core clock gating is re-enabled on D3 entry and before `done`, and after it is re-enabled on D0 entry and before reset is released.
- R6: Leaving D3 follows this order. First, core and trunk clock gating are cleared. Next, `pg_ctrl` bit 0 is rewritten to 1. Then the kept banks are ungated. Then `pwr_state` becomes 0. Then `mclk_en` is restored and the PLL shutdown bit is cleared. Then stall and reset are (re)asserted and core clock gating is set. Then reset is released. Last, stall is released.
- R7: On D0 entry, the gate bit of each bank whose bit in {`keep_dram`,`keep_iram`} is 1 is cleared, and every other bank stays gated. The keep masks are captured when the request is accepted.
- R8: While idle in D0, trunk clock gating (`cg_ctrl` bit 10) is 0.
- R9: `pg_ctrl` bit 0 is 1 at every cycle after reset.
- R10: Core clock gating is off in every cycle in which the gate mask or `pwr_state` changes.
- R11: A request that arrives while `busy` is high is ignored. The running sequence finishes normally and no further sequence starts after it.
- R12: A request for the state the block is already in produces `done` in the next cycle with `busy` low, and leaves every control output unchanged.
- R13: `busy` is high for the whole of a sequence. `done` is a one-cycle pulse in the cycle after the final step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_go | input | 1 | One-cycle transition request |
| req_d3 | input | 1 | Target state: 1 = D3, 0 = D0 |
| keep_iram | input | 10 | Instruction-SRAM banks to power on D0 entry |
| keep_dram | input | 20 | Data-SRAM banks to power on D0 entry |
| cg_ctrl | output | 32 | Clock-gating control word |
| pg_ctrl | output | 32 | SRAM power-gating control word |
| pwr_state | output | 2 | Power-state field |
| core_stall | output | 1 | Core stall |
| core_reset | output | 1 | Core reset |
| mclk_en | output | 1 | Master-clock enable |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence complete pulse |
| in_d3 | output | 1 | Current settled state is D3 |

## Verification
The D0-entry keep mask is driven with three patterns: full, partial (10 banks) and empty. These tell apart a bank wait that scales with the changed-bit count, one that is fixed, and the no-change case where the mask must not be rewritten. The D3 entries that follow start from each of those masks, so the entry-side wait is also seen at 30, 10 and 0 banks. Same-state requests from both D0 and D3 separate the immediate `done` from a real sequence. A request of the opposite direction issued in the middle of a sequence shows whether requests are gated by `busy`.

// File: rtl/dsp_pwr_pkg.sv
`timescale 1ns/1ps
package dsp_pwr_pkg;
  // clock-gating word bit positions
  localparam int CG_CORE   = 1;
  localparam int CG_TRUNK  = 10;
  localparam int CG_PLLOFF = 31;
  // power-gating word bit positions
  localparam int PG_D3PGD   = 0;
  localparam int PG_D3SPGD  = 1;
  localparam int PG_MASK_LO = 2;
  localparam int IBANKS     = 10;
  localparam int DBANKS     = 20;
  localparam int NBANK      = IBANKS + DBANKS;

  localparam logic [31:0] CG_RESET = 32'h0000_0002;
  localparam logic [31:0] PG_RESET = 32'h0000_0001;

  typedef enum logic [4:0] {
    ST_IDLE,
    EN_CGOFF, EN_HALT, EN_GATE, EN_GWAIT, EN_CLKOFF, EN_PS, EN_PSW, EN_CGON, EN_CGW,
    EX_CGOFF, EX_D3PG, EX_UNGATE, EX_GWAIT, EX_PS, EX_PSW, EX_CLKON, EX_HALT,
    EX_CGON, EX_CGW, EX_UNRST, EX_UNSTALL
  } seq_st_e;
endpackage

// File: rtl/dsp_pwr_timer.sv
`timescale 1ns/1ps
module dsp_pwr_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          expired
);
  logic [TW-1:0] cnt_q;
  logic [TW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load | (|cnt_q);
    if (load) cnt_d = load_val;
    else      cnt_d = cnt_q - TW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/dsp_pwr_bank_cnt.sv
`timescale 1ns/1ps
module dsp_pwr_bank_cnt #(
  parameter int NB = 30,
  localparam int CW = $clog2(NB + 1)
) (
  input  logic [NB-1:0] mask_cur,
  input  logic [NB-1:0] mask_tgt,
  output logic [CW-1:0] n_changed
);
  logic [NB-1:0] flip;

  for (genvar g = 0; g < NB; g++) begin : g_flip
    assign flip[g] = mask_cur[g] ^ mask_tgt[g];
  end

  always_comb begin
    n_changed = '0;
    for (int i = 0; i < NB; i++) n_changed = n_changed + CW'(flip[i]);
  end
endmodule

// File: rtl/dsp_pwr_seq_ctrl.sv
`timescale 1ns/1ps
module dsp_pwr_seq_ctrl
  import dsp_pwr_pkg::*;
#(
  parameter int DLY_CYC   = 64,
  parameter int BANK_WAIT = 18,
  parameter int TW        = 10,
  localparam int CW = $clog2(NBANK + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_go,
  input  logic             req_d3,
  input  logic [NBANK-1:0] req_keep,
  input  logic [CW-1:0]    n_changed,
  input  logic             tmr_expired,
  output logic             tmr_load,
  output logic [TW-1:0]    tmr_val,
  output logic [NBANK-1:0] mask_cur,
  output logic [NBANK-1:0] mask_tgt,
  output logic [31:0]      cg_q,
  output logic [31:0]      pg_q,
  output logic [1:0]       ps_q,
  output logic             stall_q,
  output logic             crst_q,
  output logic             mclk_q,
  output logic             busy,
  output logic             done_q,
  output logic             d3_q
);
  seq_st_e          st_q, st_d;
  logic [31:0]      cg_d, pg_d;
  logic [1:0]       ps_d;
  logic             stall_d, crst_d, mclk_d, done_d, d3_d;
  logic [NBANK-1:0] keep_q, keep_d;
  logic             upd_en;
  logic [TW-1:0]    bank_dly;

  assign busy     = (st_q != ST_IDLE);
  assign upd_en   = busy | req_go;
  assign mask_cur = pg_q[31:PG_MASK_LO];
  assign mask_tgt = (st_q == EN_GATE) ? '1 : ~keep_q;
  assign bank_dly = TW'(BANK_WAIT * int'(n_changed));

  // next-state and next-output logic
  always_comb begin
    st_d     = st_q;
    cg_d     = cg_q;
    pg_d     = pg_q;
    ps_d     = ps_q;
    stall_d  = stall_q;
    crst_d   = crst_q;
    mclk_d   = mclk_q;
    d3_d     = d3_q;
    keep_d   = keep_q;
    done_d   = 1'b0;
    tmr_load = 1'b0;
    tmr_val  = '0;
    case (st_q)
      ST_IDLE: begin
        if (req_go) begin
          if (req_d3 == d3_q) begin
            done_d = 1'b1;
          end else if (req_d3) begin
            st_d = EN_CGOFF;
          end else begin
            st_d   = EX_CGOFF;
            keep_d = req_keep;
          end
        end
      end
      // ---------------- D0 -> D3 ----------------
      EN_CGOFF: begin
        cg_d[CG_CORE]  = 1'b0;
        cg_d[CG_TRUNK] = 1'b0;
        st_d = EN_HALT;
      end
      EN_HALT: begin
        stall_d = 1'b1;
        crst_d  = 1'b1;
        st_d    = EN_GATE;
      end
      EN_GATE: begin
        pg_d[31:PG_MASK_LO] = mask_tgt;
        pg_d[PG_D3SPGD]     = 1'b0;
        tmr_load = 1'b1;
        tmr_val  = bank_dly;
        st_d     = EN_GWAIT;
      end
      EN_GWAIT: if (tmr_expired) st_d = EN_CLKOFF;
      EN_CLKOFF: begin
        cg_d[CG_PLLOFF] = 1'b1;
        mclk_d = 1'b0;
        st_d   = EN_PS;
      end
      EN_PS: begin
        ps_d     = 2'b11;
        tmr_load = 1'b1;
        tmr_val  = TW'(DLY_CYC);
        st_d     = EN_PSW;
      end
      EN_PSW: if (tmr_expired) st_d = EN_CGON;
      EN_CGON: begin
        cg_d[CG_CORE]  = 1'b1;
        cg_d[CG_TRUNK] = 1'b1;
        tmr_load = 1'b1;
        tmr_val  = TW'(DLY_CYC);
        st_d     = EN_CGW;
      end
      EN_CGW: begin
        if (tmr_expired) begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
          d3_d   = 1'b1;
        end
      end
      // ---------------- D3 -> D0 ----------------
      EX_CGOFF: begin
        cg_d[CG_CORE]  = 1'b0;
        cg_d[CG_TRUNK] = 1'b0;
        st_d = EX_D3PG;
      end
      EX_D3PG: begin
        pg_d[PG_D3PGD] = 1'b1;
        st_d = EX_UNGATE;
      end
      EX_UNGATE: begin
        pg_d[31:PG_MASK_LO] = mask_tgt;
        tmr_load = 1'b1;
        tmr_val  = bank_dly;
        st_d     = EX_GWAIT;
      end
      EX_GWAIT: if (tmr_expired) st_d = EX_PS;
      EX_PS: begin
        ps_d     = 2'b00;
        tmr_load = 1'b1;
        tmr_val  = TW'(DLY_CYC);
        st_d     = EX_PSW;
      end
      EX_PSW: if (tmr_expired) st_d = EX_CLKON;
      EX_CLKON: begin
        mclk_d = 1'b1;
        cg_d[CG_PLLOFF] = 1'b0;
        st_d = EX_HALT;
      end
      EX_HALT: begin
        stall_d = 1'b1;
        crst_d  = 1'b1;
        st_d    = EX_CGON;
      end
      EX_CGON: begin
        cg_d[CG_CORE] = 1'b1;
        tmr_load = 1'b1;
        tmr_val  = TW'(DLY_CYC);
        st_d     = EX_CGW;
      end
      EX_CGW: if (tmr_expired) st_d = EX_UNRST;
      EX_UNRST: begin
        crst_d = 1'b0;
        st_d   = EX_UNSTALL;
      end
      EX_UNSTALL: begin
        stall_d = 1'b0;
        done_d  = 1'b1;
        d3_d    = 1'b0;
        st_d    = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // state register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  // done pulse register (free-running so it always clears)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= done_d;
  end

  // control word registers, enabled only while sequencing or on a request
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cg_q    <= CG_RESET;
      pg_q    <= PG_RESET;
      ps_q    <= 2'b00;
      stall_q <= 1'b0;
      crst_q  <= 1'b0;
      mclk_q  <= 1'b1;
      d3_q    <= 1'b0;
      keep_q  <= '0;
    end else if (upd_en) begin
      cg_q    <= cg_d;
      pg_q    <= pg_d;
      ps_q    <= ps_d;
      stall_q <= stall_d;
      crst_q  <= crst_d;
      mclk_q  <= mclk_d;
      d3_q    <= d3_d;
      keep_q  <= keep_d;
    end
  end
endmodule

// File: rtl/dsp_pwr_seq.sv
`timescale 1ns/1ps
module dsp_pwr_seq
  import dsp_pwr_pkg::*;
#(
  parameter int DLY_CYC   = 64,
  parameter int BANK_WAIT = 18
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_go,
  input  logic        req_d3,
  input  logic [9:0]  keep_iram,
  input  logic [19:0] keep_dram,
  output logic [31:0] cg_ctrl,
  output logic [31:0] pg_ctrl,
  output logic [1:0]  pwr_state,
  output logic        core_stall,
  output logic        core_reset,
  output logic        mclk_en,
  output logic        busy,
  output logic        done,
  output logic        in_d3
);
  localparam int MAX_BANK_DLY = BANK_WAIT * NBANK;
  localparam int MAX_DLY = (DLY_CYC > MAX_BANK_DLY) ? DLY_CYC : MAX_BANK_DLY;
  localparam int TW = $clog2(MAX_DLY + 1);
  localparam int CW = $clog2(NBANK + 1);

  logic [NBANK-1:0] mask_cur, mask_tgt;
  logic [CW-1:0]    n_changed;
  logic             tmr_load, tmr_expired;
  logic [TW-1:0]    tmr_val;

  dsp_pwr_seq_ctrl #(
    .DLY_CYC  (DLY_CYC),
    .BANK_WAIT(BANK_WAIT),
    .TW       (TW)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_go     (req_go),
    .req_d3     (req_d3),
    .req_keep   ({keep_dram, keep_iram}),
    .n_changed  (n_changed),
    .tmr_expired(tmr_expired),
    .tmr_load   (tmr_load),
    .tmr_val    (tmr_val),
    .mask_cur   (mask_cur),
    .mask_tgt   (mask_tgt),
    .cg_q       (cg_ctrl),
    .pg_q       (pg_ctrl),
    .ps_q       (pwr_state),
    .stall_q    (core_stall),
    .crst_q     (core_reset),
    .mclk_q     (mclk_en),
    .busy       (busy),
    .done_q     (done),
    .d3_q       (in_d3)
  );

  dsp_pwr_bank_cnt #(.NB(NBANK)) u_bank (
    .mask_cur (mask_cur),
    .mask_tgt (mask_tgt),
    .n_changed(n_changed)
  );

  dsp_pwr_timer #(.TW(TW)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (tmr_load),
    .load_val(tmr_val),
    .expired (tmr_expired)
  );
endmodule

// File: rtl/dsp_pwr_seq_chk.sv
`timescale 1ns/1ps
module dsp_pwr_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_go,
  input logic        req_d3,
  input logic [31:0] cg_ctrl,
  input logic [31:0] pg_ctrl,
  input logic [1:0]  pwr_state,
  input logic        core_stall,
  input logic        core_reset,
  input logic        mclk_en,
  input logic        busy,
  input logic        done,
  input logic        in_d3
);
  // R9
  d3pgd_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pg_ctrl[0]);

  // R8
  trunk_off_d0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_d3 && !busy) |-> !cg_ctrl[10]);

  // R10
  mask_change_cg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pg_ctrl[31:2]) |-> !cg_ctrl[1]);

  // R10
  ps_change_cg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pwr_state) |-> !cg_ctrl[1]);

  // R2
  ps_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 2'b00) || (pwr_state == 2'b11));

  // R12
  same_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_go && (req_d3 == in_d3)) |=> (done && !busy));

  // R13
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6
  unreset_stalled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_reset) |-> core_stall);

  // R3
  d3_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_d3 && !busy) |-> (pwr_state == 2'b11 && !mclk_en && cg_ctrl[31] && core_stall));
endmodule

bind dsp_pwr_seq dsp_pwr_seq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_go    (req_go),
  .req_d3    (req_d3),
  .cg_ctrl   (cg_ctrl),
  .pg_ctrl   (pg_ctrl),
  .pwr_state (pwr_state),
  .core_stall(core_stall),
  .core_reset(core_reset),
  .mclk_en   (mclk_en),
  .busy      (busy),
  .done      (done),
  .in_d3     (in_d3)
);

// File: tb/sim_dsp_pwr_seq.sv
`timescale 1ns/1ps
module sim_dsp_pwr_seq;
  localparam int DLY = 64;
  localparam int BW  = 18;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_go = 1'b0;
  logic        req_d3 = 1'b0;
  logic [9:0]  keep_iram = '0;
  logic [19:0] keep_dram = '0;
  logic [31:0] cg_ctrl, pg_ctrl;
  logic [1:0]  pwr_state;
  logic        core_stall, core_reset, mclk_en, busy, done, in_d3;

  int n_chk = 0;
  int n_err = 0;

  dsp_pwr_seq #(.DLY_CYC(DLY), .BANK_WAIT(BW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_go(req_go), .req_d3(req_d3),
    .keep_iram(keep_iram), .keep_dram(keep_dram),
    .cg_ctrl(cg_ctrl), .pg_ctrl(pg_ctrl), .pwr_state(pwr_state),
    .core_stall(core_stall), .core_reset(core_reset), .mclk_en(mclk_en),
    .busy(busy), .done(done), .in_d3(in_d3)
  );

  always #4 clk = ~clk;

  // event monitor: samples 2 ns after each rising edge
  int cyc = 0;
  int t_cgoff, t_cgon, t_halt, t_unstall, t_unrst, t_gate, t_pll, t_mclk, t_ps, t_done, t_d3pg;
  int n_done = 0;
  int bad_trunk = 0;
  int bad_d3pg = 0;
  logic [31:0] p_cg, p_pg;
  logic [1:0]  p_ps;
  logic        p_stall, p_rst, p_mclk;

  task automatic clr_times();
    t_cgoff = -1; t_cgon = -1; t_halt = -1; t_unstall = -1; t_unrst = -1;
    t_gate = -1; t_pll = -1; t_mclk = -1; t_ps = -1; t_done = -1; t_d3pg = -1;
    n_done = 0;
  endtask

  always @(posedge clk) begin
    #2;
    cyc++;
    if (rst_n) begin
      if (p_cg[1] && !cg_ctrl[1]) t_cgoff = cyc;
      if (!p_cg[1] && cg_ctrl[1]) t_cgon = cyc;
      if (!p_stall && core_stall) t_halt = cyc;
      if (p_stall && !core_stall) t_unstall = cyc;
      if (p_rst && !core_reset) t_unrst = cyc;
      if (p_pg[31:2] != pg_ctrl[31:2]) t_gate = cyc;
      if (p_cg[31] != cg_ctrl[31]) t_pll = cyc;
      if (p_mclk != mclk_en) t_mclk = cyc;
      if (p_ps != pwr_state) t_ps = cyc;
      if (done) begin t_done = cyc; n_done++; end
      if (!pg_ctrl[0]) bad_d3pg++;
      if (!busy && !in_d3 && cg_ctrl[10]) bad_trunk++;
    end
    p_cg = cg_ctrl; p_pg = pg_ctrl; p_ps = pwr_state;
    p_stall = core_stall; p_rst = core_reset; p_mclk = mclk_en;
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  task automatic pulse_req(input bit d3, input logic [9:0] ki, input logic [19:0] kd);
    @(negedge clk);
    req_go = 1'b1; req_d3 = d3; keep_iram = ki; keep_dram = kd;
    @(negedge clk);
    req_go = 1'b0;
  endtask

  task automatic wait_done();
    int k;
    k = 0;
    while (!done && k < 5000) begin @(negedge clk); k++; end
    chk(done, "R13 done seen", {63'd0, done}, 64'd1);
  endtask

  task automatic t_reset();
    chk(pwr_state == 2'b00, "R1 pwr_state", pwr_state, 0);
    chk(cg_ctrl == 32'h2, "R1 cg_ctrl", cg_ctrl, 32'h2);
    chk(pg_ctrl == 32'h1, "R1 pg_ctrl", pg_ctrl, 32'h1);
    chk({mclk_en, core_stall, core_reset, busy, done, in_d3} == 6'b100000,
        "R1 flags", {mclk_en, core_stall, core_reset, busy, done, in_d3}, 6'b100000);
  endtask

  task automatic t_same(input bit d3);
    logic [31:0] cg0, pg0;
    cg0 = cg_ctrl; pg0 = pg_ctrl;
    @(negedge clk);
    req_go = 1'b1; req_d3 = d3;
    @(negedge clk);
    req_go = 1'b0;
    chk(done && !busy, "R12 immediate done", {busy, done}, 2'b01);
    @(negedge clk);
    chk(!done && !busy, "R12 no sequence", {busy, done}, 2'b00);
    chk(cg_ctrl == cg0 && pg_ctrl == pg0 && in_d3 == d3, "R12 unchanged", {cg_ctrl, pg_ctrl}, {cg0, pg0});
  endtask

  task automatic t_enter(input int banks, input bit poke);
    clr_times();
    pulse_req(1'b1, '0, '0);
    chk(busy, "R13 busy during entry", {63'd0, busy}, 1);
    if (poke) begin
      repeat (20) @(negedge clk);
      pulse_req(1'b0, 10'h3FF, 20'hFFFFF);
    end
    wait_done();
    @(negedge clk);
    if (banks > 0)
      chk(t_cgoff < t_halt && t_halt < t_gate && t_gate < t_pll && t_pll < t_ps && t_ps < t_cgon,
          "R3 entry order", t_gate, t_pll);
    else
      chk(t_cgoff < t_halt && t_halt < t_pll && t_pll < t_ps && t_ps < t_cgon && t_gate == -1,
          "R4 entry order no mask change", t_gate, -1);
    chk(t_mclk == t_pll, "R3 mclk with pll", t_mclk, t_pll);
    if (banks > 0)
      chk(t_pll - t_gate >= BW * banks, "R4 bank wait entry", t_pll - t_gate, BW * banks);
    chk(t_cgon - t_ps >= DLY, "R5 ps settle", t_cgon - t_ps, DLY);
    chk(t_done - t_cgon >= DLY, "R5 cg settle", t_done - t_cgon, DLY);
    chk(cg_ctrl == 32'h8000_0402, "R3 cg final", cg_ctrl, 32'h8000_0402);
    chk(pg_ctrl == 32'hFFFF_FFFD, "R3 pg final", pg_ctrl, 32'hFFFF_FFFD);
    chk(pwr_state == 2'b11 && in_d3 && !mclk_en && core_stall && core_reset,
        "R3 d3 flags", {pwr_state, in_d3, mclk_en, core_stall, core_reset}, 6'b111011);
    chk(!busy && !done && n_done == 1, "R13 one done pulse", n_done, 1);
    if (poke) begin
      repeat (5) @(negedge clk);
      chk(!busy && in_d3 && n_done == 1, "R11 mid request ignored", {busy, in_d3}, 2'b01);
    end
  endtask

  task automatic t_exit(input logic [9:0] ki, input logic [19:0] kd);
    int banks;
    logic [31:0] pg_exp;
    banks = $countones({kd, ki});
    pg_exp = {~kd, ~ki, 2'b01};
    clr_times();
    pulse_req(1'b0, ki, kd);
    chk(busy, "R13 busy during exit", {63'd0, busy}, 1);
    keep_iram = ~ki; keep_dram = ~kd;  // must not matter once captured
    wait_done();
    @(negedge clk);
    if (banks > 0)
      chk(t_cgoff < t_gate && t_gate < t_ps, "R6 exit order gate", t_gate, t_ps);
    else
      chk(t_cgoff < t_ps && t_gate == -1, "R4 exit no mask change", t_gate, -1);
    chk(t_ps < t_mclk && t_mclk == t_pll && t_mclk < t_cgon && t_cgon < t_unrst && t_unrst < t_unstall,
        "R6 exit order tail", t_cgon, t_unrst);
    if (banks > 0)
      chk(t_ps - t_gate >= BW * banks, "R4 bank wait exit", t_ps - t_gate, BW * banks);
    chk(t_mclk - t_ps >= DLY, "R5 ps settle exit", t_mclk - t_ps, DLY);
    chk(t_unrst - t_cgon >= DLY, "R5 cg settle exit", t_unrst - t_cgon, DLY);
    chk(pg_ctrl == pg_exp, "R7 kept banks", pg_ctrl, pg_exp);
    chk(cg_ctrl == 32'h2, "R8 cg final d0", cg_ctrl, 32'h2);
    chk(pwr_state == 2'b00 && !in_d3 && mclk_en && !core_stall && !core_reset && !busy,
        "R6 d0 flags", {pwr_state, in_d3, mclk_en, core_stall, core_reset}, 6'b000100);
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_same(1'b0);
    t_enter(30, 1'b0);
    t_same(1'b1);
    t_exit(10'h005, 20'h00F0F);
    t_enter(10, 1'b1);
    t_exit(10'h000, 20'h00000);
    t_enter(0, 1'b0);
    t_exit(10'h3FF, 20'hFFFFF);
    chk(bad_trunk == 0, "R8 trunk off in d0", bad_trunk, 0);
    chk(bad_d3pg == 0, "R9 d3pg disable held", bad_d3pg, 0);
    finish_run();
  end
endmodule